// File: doc/BRIEF.md
# Self-Programming Flash Sequencer

This block lets a small processor core rewrite its own program flash. Software writes a five-bit command into a control register. A valid command opens a short window during which the core may issue one store-program-memory strobe. That strobe carries a 16-bit address (the Z address) and a 16-bit data word. The command held in the register when the strobe arrives decides what the strobe does. It either loads one word into a temporary page buffer, refills the whole buffer with the erased value, erases a flash page, or writes the buffer into a flash page.

Page erase and page write go out to the flash array over a small handshake. The block sends a one-cycle request that carries the page number. For a write, it then streams the buffer contents one word per cycle. It then waits for a done input from the array. For the whole operation it holds the core halted. The command stays visible in the register until completion. Stimulus arriving while the block is busy is dropped.

Top module: `spm_ctrl`

## Requirements
- R1: After reset the register reads 00000, `cpu_halt`, `fl_req_erase`, `fl_req_write` and `fl_wvalid` are low, and every page buffer word holds 0xFFFF.
- R2: The register bits are: bit 0 enable, bit 1 page erase, bit 2 page write, bit 3 lock-bit read, bit 4 buffer clear. A register write takes effect only for the values 00001, 00011, 00101, 01001 and 10001. Any other value leaves the register unchanged.
- R3: After an accepted register write, a strobe is honoured on any of the next four rising edges. If no strobe comes, the register reads 00000 after the fourth edge.
- R4: A strobe under 00001 stores `spm_data` into buffer word `z_addr[5:1]`, ignoring `z_addr[0]`. The register then reads 00000.
- R5: A strobe under 10001 sets every buffer word to 0xFFFF and clears the register.
- R6: A strobe under 00011 raises `fl_req_erase` for exactly the next cycle, with `fl_page` = `z_addr[15:6]`. `spm_data` has no effect.
- R7: A strobe under 00101 raises `fl_req_write` for the next cycle, with `fl_page` = `z_addr[15:6]`. It then asserts `fl_wvalid` for 32 consecutive cycles carrying buffer words 0 to 31 in order on `fl_windex`/`fl_wdata`.
- R8: `cpu_halt` is high from the cycle after an erase or write strobe until the edge that samples `fl_done`. The register keeps the command until that same edge, then reads 00000.
- R9: While `cpu_halt` is high, register writes and strobes have no effect.
- R10: A strobe under 01001 clears the register. It issues no flash request and leaves the buffer unchanged.
- R11: When a strobe and a register write arrive in the same cycle, the strobe acts on the held command and the write is ignored.
- R12: A strobe with no armed command (register 00000 or window expired) has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 5 | Control register write value |
| reg_rdata | output | 5 | Control register contents |
| spm_strobe | input | 1 | Store-program-memory strobe from the core |
| z_addr | input | 16 | Word and page address for the strobe |
| spm_data | input | 16 | Data word for buffer loads |
| cpu_halt | output | 1 | Stalls the core during erase and write |
| fl_req_erase | output | 1 | One-cycle page erase request |
| fl_req_write | output | 1 | One-cycle page write request |
| fl_page | output | 10 | Page number for the current request |
| fl_wvalid | output | 1 | Write stream word valid |
| fl_windex | output | 5 | Buffer index of the streamed word |
| fl_wdata | output | 16 | Streamed buffer word |
| fl_done | input | 1 | Flash array completion |

## Verification
A window counter that is off by one shows up at `reg_rdata` one edge early or late, relative to the fourth edge after the write. A strobe on that boundary edge is then either honoured or dropped wrongly, which the next page stream exposes. A corrupted buffer word, a misused address bit or a missed clear stays hidden until the next page write. There the scoreboard compares all 32 streamed words in order, so the bench runs a page write after every buffer-touching scenario. A busy state that leaks shows as a register change or a second request during an erase, visible within the cycle of the stray stimulus.

// File: rtl/spm_pkg.sv
package spm_pkg;
   localparam int CMD_W = 5;

   typedef enum logic [CMD_W-1:0] {
      CMD_NONE   = 5'b00000,
      CMD_LOAD   = 5'b00001,
      CMD_ERASE  = 5'b00011,
      CMD_WRITE  = 5'b00101,
      CMD_LOCKRD = 5'b01001,
      CMD_CLRBUF = 5'b10001
   } cmd_e;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_REQ,
      SQ_STREAM,
      SQ_WAIT
   } seq_e;

   function automatic logic cmd_legal(input logic [CMD_W-1:0] v);
      return (v == CMD_LOAD) || (v == CMD_ERASE) || (v == CMD_WRITE) ||
             (v == CMD_LOCKRD) || (v == CMD_CLRBUF);
   endfunction

   function automatic logic cmd_is_long(input logic [CMD_W-1:0] v);
      return (v == CMD_ERASE) || (v == CMD_WRITE);
   endfunction
endpackage

// File: rtl/spm_cmd_reg.sv
module spm_cmd_reg
   import spm_pkg::*;
#(
   parameter int WINDOW = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CMD_W-1:0] wdata,
   input  logic             strobe,
   input  logic             busy,
   input  logic             op_done,
   output cmd_e             cmd,
   output logic             fire
);
   localparam int CW = $clog2(WINDOW + 1);

   logic [CW-1:0] cnt;
   logic          armed;

   if (WINDOW < 1) begin : g_bad_window
      $error("spm_cmd_reg: WINDOW must be at least 1");
   end

   assign armed = cmd[0] && (cnt != '0) && !busy;
   assign fire  = strobe && armed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd <= CMD_NONE;
         cnt <= '0;
      end else if (busy) begin
         cnt <= '0;
         if (op_done) cmd <= CMD_NONE;
      end else if (fire) begin
         cnt <= '0;
         if (!cmd_is_long(cmd)) cmd <= CMD_NONE;
      end else if (wr && cmd_legal(wdata)) begin
         cmd <= cmd_e'(wdata);
         cnt <= CW'(WINDOW);
      end else if (cnt == CW'(1)) begin
         cmd <= CMD_NONE;
         cnt <= '0;
      end else if (cnt != '0) begin
         cnt <= cnt - CW'(1);
      end
   end

   AST_REG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_NONE) || cmd_legal(cmd)); // R2
   AST_WINDOW_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && cnt == CW'(1) && !strobe && !wr) |=> (cmd == CMD_NONE)); // R3
   AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt <= CW'(WINDOW)) && ((cnt == '0) || cmd[0])); // R3
   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !op_done) |=> $stable(cmd)); // R9
endmodule

// File: rtl/spm_page_buf.sv
module spm_page_buf #(
   parameter int WORDS  = 32,
   parameter int DATA_W = 16,
   localparam int WB    = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic [WB-1:0]     ld_idx,
   input  logic [DATA_W-1:0] ld_data,
   input  logic              clr,
   input  logic [WB-1:0]     rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem [WORDS];

   for (genvar i = 0; i < WORDS; i++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n || clr) begin
            mem[i] <= '1;
         end else if (ld && ld_idx == WB'(i)) begin
            mem[i] <= ld_data;
         end
      end
   end

   assign rd_data = mem[rd_idx];

   AST_LD_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld && clr)); // R5
endmodule

// File: rtl/spm_page_seq.sv
module spm_page_seq
   import spm_pkg::*;
#(
   parameter int WORDS  = 32,
   parameter int DATA_W = 16,
   parameter int PAGE_W = 10,
   localparam int WB    = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_erase,
   input  logic              start_write,
   input  logic [PAGE_W-1:0] start_page,
   input  logic              fl_done,
   input  logic [DATA_W-1:0] buf_rd_data,
   output logic              busy,
   output logic              op_done,
   output logic [WB-1:0]     rd_idx,
   output logic              fl_req_erase,
   output logic              fl_req_write,
   output logic [PAGE_W-1:0] fl_page,
   output logic              fl_wvalid,
   output logic [WB-1:0]     fl_windex,
   output logic [DATA_W-1:0] fl_wdata
);
   seq_e              state;
   logic              op_wr;
   logic [PAGE_W-1:0] page_q;
   logic [WB-1:0]     idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= SQ_IDLE;
         op_wr  <= 1'b0;
         page_q <= '0;
         idx    <= '0;
      end else begin
         unique case (state)
            SQ_IDLE: begin
               if (start_erase || start_write) begin
                  state  <= SQ_REQ;
                  op_wr  <= start_write;
                  page_q <= start_page;
               end
            end
            SQ_REQ: begin
               idx   <= '0;
               state <= op_wr ? SQ_STREAM : SQ_WAIT;
            end
            SQ_STREAM: begin
               if (idx == WB'(WORDS - 1)) state <= SQ_WAIT;
               idx <= idx + WB'(1);
            end
            SQ_WAIT: begin
               if (fl_done) state <= SQ_IDLE;
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign busy         = (state != SQ_IDLE);
   assign op_done      = (state == SQ_WAIT) && fl_done;
   assign fl_req_erase = (state == SQ_REQ) && !op_wr;
   assign fl_req_write = (state == SQ_REQ) && op_wr;
   assign fl_page      = page_q;
   assign fl_wvalid    = (state == SQ_STREAM);
   assign fl_windex    = idx;
   assign rd_idx       = idx;
   assign fl_wdata     = buf_rd_data;

   AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fl_req_erase, fl_req_write, fl_wvalid})); // R6
   AST_STREAM_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fl_wvalid) |-> ($past(fl_req_write) && fl_windex == '0)); // R7
   AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_wvalid && $past(fl_wvalid)) |-> (fl_windex == $past(fl_windex) + WB'(1))); // R7
   AST_PAGE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(fl_page)); // R6
endmodule

// File: rtl/spm_ctrl.sv
module spm_ctrl
   import spm_pkg::*;
#(
   parameter int PAGE_WORDS = 32,
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 16,
   parameter int WINDOW     = 4,
   localparam int WB        = $clog2(PAGE_WORDS),
   localparam int PAGE_W    = ADDR_W - WB - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [CMD_W-1:0]  reg_wdata,
   output logic [CMD_W-1:0]  reg_rdata,
   input  logic              spm_strobe,
   input  logic [ADDR_W-1:0] z_addr,
   input  logic [DATA_W-1:0] spm_data,
   output logic              cpu_halt,
   output logic              fl_req_erase,
   output logic              fl_req_write,
   output logic [PAGE_W-1:0] fl_page,
   output logic              fl_wvalid,
   output logic [WB-1:0]     fl_windex,
   output logic [DATA_W-1:0] fl_wdata,
   input  logic              fl_done
);
   if (PAGE_WORDS < 2 || (1 << WB) != PAGE_WORDS) begin : g_bad_page
      $error("spm_ctrl: PAGE_WORDS must be a power of two, at least 2");
   end
   if (PAGE_W < 1) begin : g_bad_addr
      $error("spm_ctrl: ADDR_W too small for PAGE_WORDS");
   end

   cmd_e              cmd;
   logic              fire;
   logic              busy;
   logic              op_done;
   logic              buf_ld;
   logic              buf_clr;
   logic              go_erase;
   logic              go_write;
   logic [WB-1:0]     rd_idx;
   logic [DATA_W-1:0] rd_data;
   logic [WB-1:0]     word_idx;
   logic [PAGE_W-1:0] page_num;
   logic              unused_zlsb;

   assign word_idx    = z_addr[WB:1];
   assign page_num    = z_addr[ADDR_W-1:WB+1];
   assign unused_zlsb = z_addr[0];

   assign buf_ld   = fire && (cmd == CMD_LOAD);
   assign buf_clr  = fire && (cmd == CMD_CLRBUF);
   assign go_erase = fire && (cmd == CMD_ERASE);
   assign go_write = fire && (cmd == CMD_WRITE);

   spm_cmd_reg #(.WINDOW(WINDOW)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (reg_wr),
      .wdata   (reg_wdata),
      .strobe  (spm_strobe),
      .busy    (busy),
      .op_done (op_done),
      .cmd     (cmd),
      .fire    (fire)
   );

   spm_page_buf #(.WORDS(PAGE_WORDS), .DATA_W(DATA_W)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld      (buf_ld),
      .ld_idx  (word_idx),
      .ld_data (spm_data),
      .clr     (buf_clr),
      .rd_idx  (rd_idx),
      .rd_data (rd_data)
   );

   spm_page_seq #(.WORDS(PAGE_WORDS), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_erase  (go_erase),
      .start_write  (go_write),
      .start_page   (page_num),
      .fl_done      (fl_done),
      .buf_rd_data  (rd_data),
      .busy         (busy),
      .op_done      (op_done),
      .rd_idx       (rd_idx),
      .fl_req_erase (fl_req_erase),
      .fl_req_write (fl_req_write),
      .fl_page      (fl_page),
      .fl_wvalid    (fl_wvalid),
      .fl_windex    (fl_windex),
      .fl_wdata     (fl_wdata)
   );

   assign reg_rdata = cmd;
   assign cpu_halt  = busy;

   AST_HALT_HOLDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_halt |-> (reg_rdata[0] && cmd_is_long(reg_rdata))); // R8
   AST_REQ_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_req_erase || fl_req_write) |-> $past(spm_strobe)); // R6
   AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_halt && fl_done && !fl_req_erase && !fl_req_write && !fl_wvalid)
      |=> (!cpu_halt && reg_rdata == '0)); // R8
   AST_IDLE_NO_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_halt |-> (!fl_wvalid && !fl_req_erase && !fl_req_write)); // R1
endmodule

// File: tb/tb_spm_ctrl.sv
module tb_spm_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int PW         = 32;
   localparam int DONE_DLY   = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [4:0]  reg_wdata = '0;
   logic [4:0]  reg_rdata;
   logic        spm_strobe = 1'b0;
   logic [15:0] z_addr = '0;
   logic [15:0] spm_data = '0;
   logic        cpu_halt;
   logic        fl_req_erase, fl_req_write;
   logic [9:0]  fl_page;
   logic        fl_wvalid;
   logic [4:0]  fl_windex;
   logic [15:0] fl_wdata;
   logic        fl_done = 1'b0;

   int tests = 0;
   int fails = 0;
   bit finished = 0;

   logic [15:0] exp_buf [PW];
   logic [20:0] sb_q [$];
   int erase_reqs = 0;
   int write_reqs = 0;
   int fm_cnt = -1;
   int fm_words = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spm_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .spm_strobe(spm_strobe), .z_addr(z_addr),
      .spm_data(spm_data), .cpu_halt(cpu_halt), .fl_req_erase(fl_req_erase),
      .fl_req_write(fl_req_write), .fl_page(fl_page), .fl_wvalid(fl_wvalid),
      .fl_windex(fl_windex), .fl_wdata(fl_wdata), .fl_done(fl_done)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // flash array model and scoreboard monitor, both on the falling edge
   always @(negedge clk) begin
      fl_done = 1'b0;
      if (fl_req_erase) begin
         erase_reqs++;
         fm_cnt = DONE_DLY;
      end else if (fl_req_write) begin
         write_reqs++;
         fm_cnt = -2;
         fm_words = 0;
      end else if (fm_cnt == -2) begin
         if (fl_wvalid) fm_words++;
         if (fm_words == PW) fm_cnt = DONE_DLY;
      end else if (fm_cnt > 0) begin
         fm_cnt--;
      end else if (fm_cnt == 0) begin
         fl_done = 1'b1;
         fm_cnt = -1;
      end
      if (fl_wvalid && rst_n) begin
         if (sb_q.size() == 0) begin
            check("R7 unexpected stream word", {11'd0, fl_windex, fl_wdata}, 32'hDEAD);
         end else begin
            logic [20:0] e;
            e = sb_q.pop_front();
            check("R7 stream word", {11'd0, fl_windex, fl_wdata}, {11'd0, e});
         end
      end
   end

   task automatic reg_write(input logic [4:0] v);
      reg_wr = 1'b1; reg_wdata = v;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic strobe(input logic [15:0] z, input logic [15:0] d);
      spm_strobe = 1'b1; z_addr = z; spm_data = d;
      @(negedge clk);
      spm_strobe = 1'b0;
   endtask

   task automatic wait_idle(input string req);
      for (int i = 0; i < 400 && cpu_halt; i++) @(negedge clk);
      check({req, " halt released"}, {31'd0, cpu_halt}, 32'd0);
      check({req, " register cleared at completion"}, {27'd0, reg_rdata}, 32'd0);
   endtask

   // driver: page write pushes the expected stream into the scoreboard
   task automatic page_write(input logic [9:0] pg, input string req);
      int w0;
      for (int i = 0; i < PW; i++) sb_q.push_back({i[4:0], exp_buf[i]});
      w0 = write_reqs;
      reg_write(5'b00101);
      strobe({pg, 6'h15}, 16'h1234);
      check({req, " R8 halt after write strobe"}, {31'd0, cpu_halt}, 32'd1);
      check({req, " R7 write request"}, {31'd0, fl_req_write}, 32'd1);
      check({req, " R7 page"}, {22'd0, fl_page}, {22'd0, pg});
      @(negedge clk);
      check({req, " R8 command held"}, {27'd0, reg_rdata}, 32'h05);
      wait_idle({req, " R8"});
      check({req, " R7 one request"}, write_reqs - w0, 1);
      check({req, " R7 all words streamed"}, sb_q.size(), 0);
   endtask

   initial begin
      for (int i = 0; i < PW; i++) exp_buf[i] = 16'hFFFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 register reset", {27'd0, reg_rdata}, 0);
      check("R1 halt reset", {31'd0, cpu_halt}, 0);
      check("R1 no request", {29'd0, fl_req_erase, fl_req_write, fl_wvalid}, 0);

      page_write(10'h001, "R1 reset buffer");

      // R2: illegal patterns
      reg_write(5'b00111);
      check("R2 illegal 00111 ignored", {27'd0, reg_rdata}, 0);
      reg_write(5'b11111);
      check("R2 illegal 11111 ignored", {27'd0, reg_rdata}, 0);
      reg_write(5'b00001);
      reg_write(5'b00110);
      check("R2 illegal write keeps armed value", {27'd0, reg_rdata}, 32'h01);
      repeat (6) @(negedge clk);

      // R3: expiry after four edges
      reg_write(5'b00011);
      repeat (3) @(negedge clk);
      check("R3 still armed after three edges", {27'd0, reg_rdata}, 32'h03);
      @(negedge clk);
      check("R3 expired after fourth edge", {27'd0, reg_rdata}, 0);
      // R12: strobe after expiry does nothing
      strobe(16'h0004, 16'hBAD0);
      check("R12 no halt after expired strobe", {31'd0, cpu_halt}, 0);
      check("R12 no erase request", erase_reqs, 0);

      // R3/R4: load on the fourth edge, LSB of Z ignored
      reg_write(5'b00001);
      repeat (3) @(negedge clk);
      strobe(16'h0007, 16'hA5A5);   // word 3
      exp_buf[3] = 16'hA5A5;
      check("R4 register cleared after load", {27'd0, reg_rdata}, 0);
      reg_write(5'b00001);
      strobe(16'hFC3E, 16'h0F0F);   // word 31, page bits must not matter
      exp_buf[31] = 16'h0F0F;
      reg_write(5'b00001);
      strobe(16'h0000, 16'h1111);   // word 0
      exp_buf[0] = 16'h1111;
      // R12: strobe with register empty
      strobe(16'h0002, 16'h2222);
      page_write(10'h2AB, "R4 loads");

      // R6/R9: erase, with stimulus during busy
      reg_write(5'b00011);
      strobe({10'h155, 6'h00}, 16'hCAFE);
      check("R6 erase request", {31'd0, fl_req_erase}, 1);
      check("R6 erase page", {22'd0, fl_page}, 32'h155);
      check("R8 halt during erase", {31'd0, cpu_halt}, 1);
      reg_write(5'b00001);
      check("R9 write while busy ignored", {27'd0, reg_rdata}, 32'h03);
      strobe(16'h0008, 16'h7777);
      check("R9 strobe while busy: no request", {30'd0, fl_req_erase, fl_req_write}, 0);
      wait_idle("R6 erase");
      check("R6 single erase request", erase_reqs, 1);
      page_write(10'h003, "R9 buffer untouched");

      // R10: lock-bit read
      reg_write(5'b01001);
      strobe(16'h000A, 16'h3333);
      check("R10 register cleared", {27'd0, reg_rdata}, 0);
      repeat (3) @(negedge clk);
      check("R10 no flash request", erase_reqs, 1);
      check("R10 halt low", {31'd0, cpu_halt}, 0);

      // R11: strobe and write together
      reg_write(5'b00001);
      reg_wr = 1'b1; reg_wdata = 5'b00011;
      strobe(16'h000C, 16'h4444);  // word 6
      reg_wr = 1'b0;
      exp_buf[6] = 16'h4444;
      check("R11 write ignored on strobe cycle", {27'd0, reg_rdata}, 0);
      check("R11 no halt", {31'd0, cpu_halt}, 0);
      page_write(10'h004, "R10 R11 buffer");

      // R5: clear buffer
      reg_write(5'b10001);
      strobe(16'h0000, 16'h5555);
      check("R5 register cleared", {27'd0, reg_rdata}, 0);
      for (int i = 0; i < PW; i++) exp_buf[i] = 16'hFFFF;
      page_write(10'h3FF, "R5 cleared buffer");

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule